// File: doc/BRIEF.md
# System Configuration Register with I/O Decode Qualification

This block holds one 8-bit configuration word written by the CPU over its I/O bus, together with the small amount of logic that the word steers. It decodes the 16-bit I/O address into three selects: the configuration register itself, a low group of on-chip registers, and a high group of registers whose address bits 7:6 are `11`. One configuration bit decides at run time whether the upper address byte is checked for the high group.

The other configuration bits control these functions:
- One bit forces the active-low ROM chip select inactive.
- One bit halves the serial controller's clock by turning its clock enable into a pulse on every second CPU clock.
- One bit moves three shared pins from their handshake and asynchronous-clock roles to clocked-serial transmit, receive and clock roles.
- One bit lets read data from on-chip registers drive the external data pins, for an emulator mode.
- Three bits form an interrupt daisy-chain routing code, which is passed out to the chain logic unchanged.

Top module: `sys_cfg_decode`

## Requirements
- R1: After reset the configuration word is 0x00. In that state `rom_cs_n` follows `rom_dec_n`, `pclk_en` is high, `pin_csio` is 0, `daisy_code` is 0 and `data_drive_en` is 0.
- R2: A cycle with `io_wr` high and `cfg_sel` high loads `wr_data` into the word at the next clock edge. A read (`io_rd`) with `cfg_sel` high returns the last value written on `rd_data`. `rd_data` is 0x00 whenever that read is not taking place. Writes to any other address leave the word unchanged.
- R3: With bit 7 clear, `hi_sel` is high during a strobe (`io_rd` or `io_wr`) whenever `io_addr[7:6]` is `11`, whatever `io_addr[15:8]` holds.
- R4: With bit 7 set, `hi_sel` also requires `io_addr[15:8]` to be zero.
- R5: `cfg_sel` needs a strobe, `io_addr[15:8]` zero and `io_addr[7:0]` equal to `CFG_ADDR`. `lo_sel` needs a strobe, `io_addr[15:8]` zero and `io_addr[7:6]` equal to `LO_PAGE`, at any address other than `CFG_ADDR`. At most one of the three selects is high at a time.
- R6: With bit 5 set, `rom_cs_n` is held high. With bit 5 clear, it equals `rom_dec_n`.
- R7: `pin_csio` equals bit 4: 0 selects the handshake and asynchronous-clock pin roles, 1 selects the clocked-serial roles.
- R8: With bit 3 clear, `pclk_en` is high on every cycle. With bit 3 set, `pclk_en` alternates high and low on successive cycles.
- R9: `data_drive_en` is high exactly when bit 2 is set, `io_rd` is high and one of `cfg_sel`, `lo_sel` or `hi_sel` is high.
- R10: `daisy_code` is {bit 6, bit 1, bit 0} of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| wr_data | input | 8 | Write data |
| rom_dec_n | input | 1 | Raw active-low ROM decode |
| rd_data | output | 8 | Configuration word on a read of its address, else 0 |
| cfg_sel | output | 1 | Configuration register select |
| lo_sel | output | 1 | Low register group select |
| hi_sel | output | 1 | High register group select |
| rom_cs_n | output | 1 | Gated active-low ROM chip select |
| pclk_en | output | 1 | Serial controller clock enable |
| pin_csio | output | 1 | Shared pin role select |
| data_drive_en | output | 1 | Drive read data onto the external data pins |
| daisy_code | output | 3 | Interrupt daisy-chain routing code |

## Verification
The bench builds the block with its defaults, `CFG_ADDR` = 0x3E and `LO_PAGE` = `00`. This places the configuration register inside the low group, so the bench can check that `lo_sel` stands aside for that one address. Random write data switches bit 7 on and off across many cycles, so high-group addresses with non-zero upper bytes are seen under both decode rules. Random data also toggles bit 3 mid-run, which exercises the moment when `pclk_en` switches between full rate and half rate.

// File: rtl/sys_cfg_decode.sv
module sys_cfg_decode #(
  parameter int         AW       = 16,
  parameter logic [7:0] CFG_ADDR = 8'h3E,
  parameter logic [1:0] LO_PAGE  = 2'b00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [7:0]    wr_data,
  input  logic          rom_dec_n,
  output logic [7:0]    rd_data,
  output logic          cfg_sel,
  output logic          lo_sel,
  output logic          hi_sel,
  output logic          rom_cs_n,
  output logic          pclk_en,
  output logic          pin_csio,
  output logic          data_drive_en,
  output logic [2:0]    daisy_code
);
  localparam int UW = AW - 8;

  logic [7:0] cfg_r;
  logic       half_ph;
  logic       strobe, upper_zero, hi_page, is_cfg_addr;

  assign strobe      = io_rd | io_wr;
  assign upper_zero  = (io_addr[AW-1:8] == '0);
  assign hi_page     = (io_addr[7:6] == 2'b11);
  assign is_cfg_addr = (io_addr[7:0] == CFG_ADDR);

  assign cfg_sel = strobe & upper_zero & is_cfg_addr;
  assign lo_sel  = strobe & upper_zero & (io_addr[7:6] == LO_PAGE) & ~is_cfg_addr;
  assign hi_sel  = strobe & hi_page & (~cfg_r[7] | upper_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cfg_r <= 8'h00;
    else if (io_wr && cfg_sel) cfg_r <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_ph <= 1'b0;
    else        half_ph <= ~half_ph;
  end

  assign rd_data       = (cfg_sel && io_rd) ? cfg_r : 8'h00;
  assign rom_cs_n      = rom_dec_n | cfg_r[5];
  assign pin_csio      = cfg_r[4];
  assign pclk_en       = ~cfg_r[3] | half_ph;
  assign data_drive_en = cfg_r[2] & io_rd & (cfg_sel | lo_sel | hi_sel);
  assign daisy_code    = {cfg_r[6], cfg_r[1], cfg_r[0]};

  logic [UW-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/sys_cfg_decode_chk.sv
module sys_cfg_decode_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] io_addr,
  input logic          io_rd,
  input logic          io_wr,
  input logic [7:0]    wr_data,
  input logic [7:0]    cfg_r,
  input logic          cfg_sel,
  input logic          lo_sel,
  input logic          hi_sel,
  input logic          rom_cs_n,
  input logic          pclk_en,
  input logic          data_drive_en
);
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && cfg_sel) |=> (cfg_r == $past(wr_data))); // R2
  AST_HI_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_r[7] && hi_sel) |-> (io_addr[AW-1:8] == '0)); // R4
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_sel, lo_sel, hi_sel})); // R5
  AST_ROM_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_r[5] |-> rom_cs_n); // R6
  AST_PCLK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_r[3] |-> pclk_en); // R8
  AST_PCLK_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_r[3] && pclk_en) |=> (!pclk_en || !cfg_r[3])); // R8
  AST_DRIVE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    data_drive_en |-> (io_rd && cfg_r[2])); // R9
endmodule

bind sys_cfg_decode sys_cfg_decode_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .wr_data(wr_data), .cfg_r(cfg_r), .cfg_sel(cfg_sel), .lo_sel(lo_sel),
  .hi_sel(hi_sel), .rom_cs_n(rom_cs_n), .pclk_en(pclk_en),
  .data_drive_en(data_drive_en)
);

// File: tb/test_sys_cfg_decode.sv
module test_sys_cfg_decode;
  localparam logic [7:0] CFG = 8'h3E;
  localparam logic [1:0] LOP = 2'b00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_rd = 0, io_wr = 0, rom_dec_n = 1;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic cfg_sel, lo_sel, hi_sel, rom_cs_n, pclk_en, pin_csio, data_drive_en;
  logic [2:0] daisy_code;

  int checks = 0, fails = 0;
  logic [7:0] mdl = 8'h00;
  logic pv_en, pv_div, pv_ok;

  always #4 clk = ~clk;

  sys_cfg_decode i_sys_cfg_decode (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .wr_data(wr_data), .rom_dec_n(rom_dec_n), .rd_data(rd_data),
    .cfg_sel(cfg_sel), .lo_sel(lo_sel), .hi_sel(hi_sel), .rom_cs_n(rom_cs_n),
    .pclk_en(pclk_en), .pin_csio(pin_csio), .data_drive_en(data_drive_en),
    .daisy_code(daisy_code)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic e_cfg(logic [15:0] a, logic rd, logic wr);
    return (rd | wr) && a[15:8] == 0 && a[7:0] == CFG;
  endfunction
  function automatic logic e_lo(logic [15:0] a, logic rd, logic wr);
    return (rd | wr) && a[15:8] == 0 && a[7:6] == LOP && a[7:0] != CFG;
  endfunction
  function automatic logic e_hi(logic [15:0] a, logic rd, logic wr, logic [7:0] m);
    return (rd | wr) && a[7:6] == 2'b11 && (!m[7] || a[15:8] == 0);
  endfunction

  task automatic chk_all();
    logic c, l, h;
    c = e_cfg(io_addr, io_rd, io_wr);
    l = e_lo(io_addr, io_rd, io_wr);
    h = e_hi(io_addr, io_rd, io_wr, mdl);
    chk("R2 rd_data", rd_data, (c && io_rd) ? mdl : 8'h00);
    chk(mdl[7] ? "R4 hi_sel" : "R3 hi_sel", hi_sel, h);
    chk("R5 cfg_sel", cfg_sel, c);
    chk("R5 lo_sel", lo_sel, l);
    chk("R6 rom_cs_n", rom_cs_n, rom_dec_n | mdl[5]);
    chk("R7 pin_csio", pin_csio, mdl[4]);
    chk("R9 data_drive_en", data_drive_en, mdl[2] & io_rd & (c | l | h));
    chk("R10 daisy_code", daisy_code, {mdl[6], mdl[1], mdl[0]});
    if (!mdl[3]) chk("R8 pclk_en full rate", pclk_en, 1'b1);
    else if (pv_ok && pv_div) chk("R8 pclk_en alternates", pclk_en, !pv_en);
  endtask

  task automatic cyc(logic [15:0] a, logic rd, logic wr, logic [7:0] d, logic rom);
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr; wr_data = d; rom_dec_n = rom;
    #1 chk_all();
    pv_en = pclk_en; pv_div = mdl[3]; pv_ok = 1'b1;
    @(posedge clk);
    if (wr && e_cfg(a, rd, wr)) mdl = d;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    pv_ok = 0; pv_en = 0; pv_div = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk("R1 reset pclk_en", pclk_en, 1'b1);
    chk("R1 reset rom_cs_n", rom_cs_n, 1'b1);
    chk("R1 reset daisy_code", daisy_code, 3'b000);
    chk("R1 reset pin_csio", pin_csio, 1'b0);
    rst_n = 1'b1;
    cyc(16'h0000, 0, 0, 0, 0);
    chk("R1 rom_cs_n follows decode", rom_cs_n, 1'b0);
    cyc(16'hABC0, 1, 0, 0, 1);
    chk("R3 hi_sel upper ignored", hi_sel, 1'b1);
    cyc({8'h00, CFG}, 0, 1, 8'h80, 1);
    cyc(16'hABC0, 1, 0, 0, 1);
    chk("R4 hi_sel upper nonzero", hi_sel, 1'b0);
    cyc(16'h00C5, 1, 0, 0, 1);
    chk("R4 hi_sel upper zero", hi_sel, 1'b1);
    cyc({8'h01, CFG}, 0, 1, 8'hFF, 1);
    cyc({8'h00, CFG}, 1, 0, 0, 1);
    chk("R2 write to other address ignored", rd_data, 8'h80);
    cyc({8'h00, CFG}, 0, 1, 8'h77, 0);
    cyc({8'h00, CFG}, 1, 0, 0, 0);
    chk("R2 readback", rd_data, 8'h77);
    chk("R9 drive on cfg read", data_drive_en, 1'b1);
    chk("R6 rom forced", rom_cs_n, 1'b1);
    chk("R7 csio roles", pin_csio, 1'b1);
    chk("R10 daisy", daisy_code, 3'b111);
    cyc({8'h00, CFG}, 0, 0, 0, 0);
    chk("R5 no strobe no select", cfg_sel, 1'b0);
    for (int i = 0; i < 8; i++) cyc(16'h0010, 1, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [2:0] k;
      k = 3'($urandom);
      a = 16'($urandom);
      if (k[0]) a[15:8] = 8'h00;
      if (k == 3'd2) a = {8'h00, CFG};
      cyc(a, k[1], k[2] | (k == 3'd2), 8'($urandom), 1'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule